// File: doc/BRIEF.md
# Cache Line Coherence Policy Unit

This block decides, for a single access to one cache line, what the cache and the memory system must do. Its inputs are the two global cache control bits, the resolved page attributes, the sampled write-back hint, the access type, the tag-lookup hit and the line's current coherence state. From these it works out the line's next coherence state and whether the cache array is written, whether memory is written and whether a line fill is requested. It also flags the one control-bit combination that is illegal.

The four control-bit modes behave differently. The normal mode runs write-back coherence with allocation on read misses. The fill-disabled mode still serves hits and writes shared lines through. The fully disabled mode still serves hits but never writes memory on a hit. The illegal mode raises only a fault. A request is taken with `req_valid`, and all results appear together on registered outputs one clock later, qualified by `resp_valid`.

Top module: `cmp_policy_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `resp_valid`, `fault`, `fill_req`, `mem_wr` and `cache_wr` are low.
- R2: A request sampled with `req_valid` high is answered on the next rising edge with `resp_valid` high. A cycle with `req_valid` low gives `resp_valid`, `fault`, `fill_req`, `mem_wr` and `cache_wr` low one edge later.
- R3: With `cd`=0 and `nw`=1, `fault` is raised, the other action outputs are low and `next_state` equals `cur_state`.
- R4: In normal mode (`cd`=0, `nw`=0), a read miss requests a fill unless `pcd` is high. The filled line's next state is Exclusive when `wb_hint`=1 and `pwt`=0, and Shared otherwise. Without a fill the state is unchanged. The state encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R5: In any legal mode, a read hit performs no action and leaves the state unchanged.
- R6: In normal mode, a write hit to an Exclusive or Modified line writes the cache, does not write memory, and yields Modified.
- R7: With `nw`=0 in a legal mode, a write hit to a Shared line writes both the cache and memory. It yields Exclusive when `pwt`=0 and `wb_hint`=1, and stays Shared otherwise.
- R8: With `cd`=1, a read miss never requests a fill. In the fill-disabled mode (`cd`=1, `nw`=0), a write hit to Exclusive or Modified writes only the cache and yields Modified.
- R9: In the fully disabled mode (`cd`=1, `nw`=1), a write hit writes the cache and never memory. Exclusive goes to Modified, Shared stays Shared and Modified stays Modified.
- R10: In any legal mode, a write miss writes memory only: no cache write, no fill, and the state is unchanged.
- R11: A `hit` of 1 with `cur_state` Invalid is handled exactly as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| cd | input | 1 | Global cache-disable control bit |
| nw | input | 1 | Global no-writethrough control bit |
| pcd | input | 1 | Resolved page cache-disable attribute |
| pwt | input | 1 | Resolved page writethrough attribute |
| wb_hint | input | 1 | Sampled write-back hint level (1 = write-back allowed) |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| hit | input | 1 | Tag-lookup hit |
| cur_state | input | 2 | Current coherence state of the line |
| resp_valid | output | 1 | Results below are valid |
| next_state | output | 2 | Next coherence state |
| cache_wr | output | 1 | Write the cache array |
| mem_wr | output | 1 | Issue an external memory write |
| fill_req | output | 1 | Request a line fill |
| fault | output | 1 | Illegal control-bit combination |

## Verification
Every result of a request is due in the cycle after the edge that samples it. This covers the next state, the three action flags, the fault and `resp_valid`. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, so exactly one rising edge lies between stimulus and check. Back-to-back requests are checked in consecutive cycles to confirm that no result leaks into the next one. An idle cycle and a reset are each checked one edge after they are applied.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MESI_W = 2;

  typedef enum logic [MESI_W-1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  // mode value equals {cd, nw}
  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_BADCFG = 2'b01,
    MD_NOFILL = 2'b10,
    MD_OFF    = 2'b11
  } mode_t;

  typedef struct packed {
    logic  fault;
    logic  fill;
    logic  mem_wr;
    logic  cache_wr;
    mesi_t nxt;
  } action_t;
endpackage

// File: rtl/cmp_mode_decode.sv
module cmp_mode_decode
  import cmp_pkg::*;
(
  input  logic              cd,
  input  logic              nw,
  input  logic              pwt,
  input  logic              wb_hint,
  input  logic              hit,
  input  logic [MESI_W-1:0] cur_state,
  output mode_t             mode,
  output logic              eff_hit,
  output logic              upgrade
);
  always_comb begin
    mode    = mode_t'({cd, nw});
    // a hit on an Invalid line is not a real hit
    eff_hit = hit && (cur_state != ST_I);
    // exclusive ownership allowed: write-back hint high, page not writethrough
    upgrade = wb_hint && !pwt;
  end
endmodule

// File: rtl/cmp_read_policy.sv
module cmp_read_policy
  import cmp_pkg::*;
(
  input  mode_t             mode,
  input  logic              eff_hit,
  input  logic              pcd,
  input  logic              upgrade,
  input  logic [MESI_W-1:0] cur_state,
  output action_t           act
);
  always_comb begin
    act     = '0;
    act.nxt = mesi_t'(cur_state);
    if (!eff_hit && mode == MD_NORMAL && !pcd) begin
      act.fill = 1'b1;
      act.nxt  = upgrade ? ST_E : ST_S;
    end
  end
endmodule

// File: rtl/cmp_write_policy.sv
module cmp_write_policy
  import cmp_pkg::*;
(
  input  mode_t             mode,
  input  logic              eff_hit,
  input  logic              upgrade,
  input  logic [MESI_W-1:0] cur_state,
  output action_t           act
);
  always_comb begin
    act     = '0;
    act.nxt = mesi_t'(cur_state);
    if (!eff_hit) begin
      act.mem_wr = 1'b1;
    end else begin
      act.cache_wr = 1'b1;
      case (mesi_t'(cur_state))
        ST_S: begin
          if (mode != MD_OFF) begin
            act.mem_wr = 1'b1;
            if (upgrade) act.nxt = ST_E;
          end
        end
        ST_E, ST_M: act.nxt = ST_M;
        default: act.nxt = mesi_t'(cur_state);
      endcase
    end
  end
endmodule

// File: rtl/cmp_resp_reg.sv
module cmp_resp_reg
  import cmp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  action_t in_act,
  output logic    out_valid,
  output action_t out_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_act   <= '0;
    end else begin
      out_valid <= in_valid;
      out_act   <= in_valid ? in_act : '0;
    end
  end

  // R1: quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_act.fault && !out_act.fill && !out_act.mem_wr && !out_act.cache_wr));

  // R2: idle cycles clear the result
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_act.mem_wr && !out_act.cache_wr && !out_act.fill));
endmodule

// File: rtl/cmp_policy_top.sv
module cmp_policy_top
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              cd,
  input  logic              nw,
  input  logic              pcd,
  input  logic              pwt,
  input  logic              wb_hint,
  input  logic              is_write,
  input  logic              hit,
  input  logic [MESI_W-1:0] cur_state,
  output logic              resp_valid,
  output logic [MESI_W-1:0] next_state,
  output logic              cache_wr,
  output logic              mem_wr,
  output logic              fill_req,
  output logic              fault
);
  mode_t   mode;
  logic    eff_hit;
  logic    upgrade;
  action_t rd_act;
  action_t wr_act;
  action_t sel_act;
  action_t reg_act;

  cmp_mode_decode u_dec (
    .cd(cd), .nw(nw), .pwt(pwt), .wb_hint(wb_hint), .hit(hit),
    .cur_state(cur_state), .mode(mode), .eff_hit(eff_hit), .upgrade(upgrade)
  );

  cmp_read_policy u_rd (
    .mode(mode), .eff_hit(eff_hit), .pcd(pcd), .upgrade(upgrade),
    .cur_state(cur_state), .act(rd_act)
  );

  cmp_write_policy u_wr (
    .mode(mode), .eff_hit(eff_hit), .upgrade(upgrade),
    .cur_state(cur_state), .act(wr_act)
  );

  always_comb begin
    sel_act = is_write ? wr_act : rd_act;
    if (mode == MD_BADCFG) begin
      sel_act       = '0;
      sel_act.fault = 1'b1;
      sel_act.nxt   = mesi_t'(cur_state);
    end
  end

  cmp_resp_reg u_reg (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_act(sel_act),
    .out_valid(resp_valid), .out_act(reg_act)
  );

  assign next_state = reg_act.nxt;
  assign cache_wr   = reg_act.cache_wr;
  assign mem_wr     = reg_act.mem_wr;
  assign fill_req   = reg_act.fill;
  assign fault      = reg_act.fault;

  // R2: one-cycle response
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R3: illegal mode faults with no action
  a_r3_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cd && nw) |=> (fault && !cache_wr && !mem_wr && !fill_req));

  // R5: read hits do nothing in legal modes
  a_r5_read_hit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !is_write && hit && cur_state != ST_I && !(!cd && nw))
      |=> (!cache_wr && !mem_wr && !fill_req && next_state == $past(cur_state)));

  // R8: no fill while caching is disabled
  a_r8_no_fill: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cd) |=> !fill_req);

  // R9: fully disabled write hits stay out of memory
  a_r9_off_write_hit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cd && nw && is_write && hit && cur_state != ST_I) |=> (cache_wr && !mem_wr));

  // R10: write misses never fill or write the cache
  a_r10_write_miss: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_write && !(!cd && nw) && (!hit || cur_state == ST_I))
      |=> (mem_wr && !cache_wr && !fill_req));
endmodule

// File: tb/cmp_policy_top_tb_top.sv
`timescale 1ns/1ps
module cmp_policy_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic cd = 1'b0, nw = 1'b0, pcd = 1'b0, pwt = 1'b0, wb_hint = 1'b0;
  logic is_write = 1'b0, hit = 1'b0;
  logic [1:0] cur_state = 2'b00;
  logic resp_valid, cache_wr, mem_wr, fill_req, fault;
  logic [1:0] next_state;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_policy_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cd(cd), .nw(nw),
    .pcd(pcd), .pwt(pwt), .wb_hint(wb_hint), .is_write(is_write), .hit(hit),
    .cur_state(cur_state), .resp_valid(resp_valid), .next_state(next_state),
    .cache_wr(cache_wr), .mem_wr(mem_wr), .fill_req(fill_req), .fault(fault)
  );

  // stimulus {cd,nw}_{pcd,pwt,wb}_{wr,hit}_{state} ; expected {fault,fill,mem,cwr}_{next}
  // states: I=00 S=01 E=10 M=11
  localparam int NV = 25;
  localparam logic [14:0] VEC [NV] = '{
    15'b00_001_00_00_0100_10, // R4 fill to E
    15'b00_000_00_00_0100_01, // R4 fill to S, hint low
    15'b00_011_00_00_0100_01, // R4 fill to S, pwt high
    15'b00_101_00_00_0000_00, // R4 pcd blocks fill
    15'b00_001_01_10_0000_10, // R5 normal read hit
    15'b00_000_11_10_0001_11, // R6 E to M
    15'b00_000_11_11_0001_11, // R6 M to M
    15'b00_000_11_01_0011_01, // R7 S stays S
    15'b00_001_11_01_0011_10, // R7 S upgrades to E
    15'b00_000_10_00_0010_00, // R10 normal write miss
    15'b01_000_01_01_1000_01, // R3 read in bad mode
    15'b01_001_10_00_1000_00, // R3 write in bad mode
    15'b10_001_00_00_0000_00, // R8 no fill, fill-disabled mode
    15'b10_000_01_11_0000_11, // R5 read hit, fill-disabled mode
    15'b10_001_11_01_0011_10, // R7 fill-disabled S upgrade
    15'b10_011_11_01_0011_01, // R7 fill-disabled S stays
    15'b10_000_11_10_0001_11, // R8 fill-disabled E to M
    15'b10_000_10_00_0010_00, // R10 fill-disabled write miss
    15'b11_001_00_00_0000_00, // R8 no fill, fully disabled
    15'b11_000_11_10_0001_11, // R9 E to M
    15'b11_001_11_01_0001_01, // R9 S stays S, no memory
    15'b11_000_11_11_0001_11, // R9 M stays M
    15'b11_000_10_00_0010_00, // R10 fully disabled write miss
    15'b00_001_01_00_0100_10, // R11 read hit on I is a miss
    15'b11_000_11_00_0010_00  // R11 write hit on I is a miss
  };
  localparam int VREQ [NV] = '{4,4,4,4,5,6,6,7,7,10,3,3,8,5,7,7,8,10,8,9,9,9,10,11,11};

  task automatic drive(input logic [8:0] s);
    {cd, nw, pcd, pwt, wb_hint, is_write, hit, cur_state} = s;
    req_valid = 1'b1;
  endtask

  task automatic check(input int req, input logic v, input logic [5:0] exp);
    logic [5:0] act;
    act = {fault, fill_req, mem_wr, cache_wr, next_state};
    n_checks++;
    if (resp_valid !== v || (v && act !== exp) || (!v && act[5:2] !== 4'b0000)) begin
      n_fail++;
      $display("FAIL R%0d: valid=%b out=%b expected valid=%b out=%b", req, resp_valid, act, v, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 6'b0); // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 6'b0); // R1 after reset, no request
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:6]);
      @(negedge clk);
      check(VREQ[i], 1'b1, VEC[i][5:0]);
    end
    // R2 idle cycle clears result
    req_valid = 1'b0;
    @(negedge clk);
    check(2, 1'b0, 6'b0);
    // R2 back-to-back: fill then write hit, each one edge later
    drive(9'b00_001_00_00);
    @(negedge clk);
    check(2, 1'b1, 6'b0100_10);
    drive(9'b11_000_11_10);
    @(negedge clk);
    check(2, 1'b1, 6'b0001_11);
    // R1 reset during activity
    drive(9'b00_000_10_00);
    rst = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 6'b0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 6'b0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule